// File: doc/BRIEF.md
# Shared-Memory Multi-Queue FIFO

This block buffers data words for up to four independent FIFO queues that all live in a single shared storage array. The array is divided into fixed blocks of 256 words. Each queue is given a contiguous run of blocks through a configuration port. Both ports run on one clock.

The write port has a queue-select input that steers each accepted word into one queue. A full flag and an almost-full flag report the state of the queue that is currently selected for writing.

The read port works in first-word-fall-through fashion. The queue chosen by the read-select input presents its oldest word on the output register without any read request. Each read request then consumes the presented word and brings the next one forward. When the read selection changes, the output spends one cycle invalid and then shows the head of the new queue. If the new queue has nothing in it, the output keeps the last word and stays invalid. An almost-empty flag reports the state of the queue that the read port has registered as selected.

Top module: `mq_fifo`

## Requirements
- R1: After reset, every queue has zero blocks and is empty. `rd_valid` is 0, `rd_data` is 0, and `full`, `almost_full` and `almost_empty` are all 1.
- R2: A configuration cycle (`cfg_we`=1) sets queue `cfg_q`. Its capacity becomes `cfg_blocks`×256 words, its storage starts at word `cfg_base`×256, its thresholds are set, and its contents are cleared.
- R3: A queue with zero blocks is always both full and empty. Writes to it are discarded and it never produces valid read data.
- R4: A write with `wr_en`=1 is accepted only when the queue selected by `wr_sel` holds fewer words than its capacity. `full` is 1 exactly when that queue's word count equals its capacity.
- R5: Each queue returns its accepted words in write order. A queue's contents are not affected by traffic to other queues.
- R6: When `rd_valid` is 0 and the registered read queue holds a word, that queue's oldest word appears on `rd_data` with `rd_valid`=1 one cycle later, with no read request. A cycle with `rd_en`=1 and `rd_valid`=1 removes that word and presents the next one in the following cycle, or drops `rd_valid` if none is left. The presented word still counts toward the queue's word count.
- R7: When `rd_sel` differs from the registered read queue, `rd_valid` is 0 in the next cycle and nothing is removed. In the cycle after that, the new queue's head is presented if it has one. `rd_data` never changes while `rd_valid` is 0.
- R8: `almost_full` is 1 when the word count plus the queue's almost-full offset is at least its capacity, for the queue selected by `wr_sel`.
- R9: `almost_empty` is 1 when the word count is at most the queue's almost-empty offset, for the registered read queue.
- R10: A word written into the registered read queue while that queue is empty and output is invalid is presented in the next cycle. A write and a read to the same queue in one cycle both take effect.
- R11: During a configuration cycle, write and read requests are ignored, and `rd_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load configuration for one queue |
| cfg_q | input | 2 | Queue being configured |
| cfg_base | input | 2 | First block index of the queue |
| cfg_blocks | input | 3 | Number of blocks (0 to 4) |
| cfg_af_off | input | 11 | Almost-full offset in words |
| cfg_ae_off | input | 11 | Almost-empty offset in words |
| wr_en | input | 1 | Write request |
| wr_sel | input | 2 | Queue targeted by writes |
| wr_data | input | 32 | Write data |
| full | output | 1 | Write-selected queue is full |
| almost_full | output | 1 | Write-selected queue is at or above its almost-full level |
| rd_en | input | 1 | Consume the presented word |
| rd_sel | input | 2 | Queue to be read |
| rd_data | output | 32 | Output register |
| rd_valid | output | 1 | `rd_data` holds an unconsumed word of the registered read queue |
| almost_empty | output | 1 | Registered read queue is at or below its almost-empty level |

## Verification
A wrong pointer or word count inside one queue shows up at the ports within a few cycles. It appears as a data mismatch at that queue's next presented word, a `full` or `almost_full` flag that flips at the wrong count during a fill, or an `almost_empty` flag that is off by one. An error in the output-register handling shows in the cycle right after a queue switch, a read request or a write into an empty selected queue. In those cases `rd_valid` or `rd_data` diverges from a behavioural model that is compared on every clock. Long random traffic with rare read-queue switches checks that the queues stay isolated and that no word is lost or duplicated.

// File: rtl/mq_pkg.sv
package mq_pkg;

    // Per-queue operation strobes issued by the top for one cycle
    typedef struct packed {
        logic cfg;
        logic push;
        logic pop;
    } q_op_t;

endpackage

// File: rtl/mq_queue_ctl.sv
module mq_queue_ctl
    import mq_pkg::*;
#(
    parameter int BLK_WORDS = 256,
    parameter int NBLK      = 4,
    localparam int BLK_SH   = $clog2(BLK_WORDS),
    localparam int ADDR_W   = $clog2(NBLK * BLK_WORDS),
    localparam int CNT_W    = ADDR_W + 1,
    localparam int BIDX_W   = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int BCNT_W   = $clog2(NBLK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  q_op_t             op,
    input  logic [BIDX_W-1:0] cfg_base,
    input  logic [BCNT_W-1:0] cfg_blocks,
    input  logic [CNT_W-1:0]  cfg_af,
    input  logic [CNT_W-1:0]  cfg_ae,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] rd_next_addr,
    output logic [CNT_W-1:0]  level,
    output logic              full,
    output logic              afull,
    output logic              aempty
);

    typedef struct packed {
        logic [BIDX_W-1:0] base;
        logic [BCNT_W-1:0] blocks;
        logic [CNT_W-1:0]  af;
        logic [CNT_W-1:0]  ae;
        logic [ADDR_W-1:0] wp;
        logic [ADDR_W-1:0] rp;
        logic [CNT_W-1:0]  cnt;
    } qstate_t;

    qstate_t           s_q, s_d;
    logic [CNT_W-1:0]  cap;
    logic [ADDR_W-1:0] origin;
    logic [ADDR_W-1:0] wp_inc;
    logic [ADDR_W-1:0] rp_inc;

    // Capacity and origin follow from the block allocation
    always_comb begin
        cap    = CNT_W'(s_q.blocks) << BLK_SH;
        origin = ADDR_W'(s_q.base) << BLK_SH;
        wp_inc = (({1'b0, s_q.wp} + CNT_W'(1)) == cap) ? '0 : s_q.wp + ADDR_W'(1);
        rp_inc = (({1'b0, s_q.rp} + CNT_W'(1)) == cap) ? '0 : s_q.rp + ADDR_W'(1);
    end

    always_comb begin
        s_d = s_q;
        if (op.cfg) begin
            s_d.base   = cfg_base;
            s_d.blocks = cfg_blocks;
            s_d.af     = cfg_af;
            s_d.ae     = cfg_ae;
            s_d.wp     = '0;
            s_d.rp     = '0;
            s_d.cnt    = '0;
        end else begin
            if (op.push) s_d.wp = wp_inc;
            if (op.pop)  s_d.rp = rp_inc;
            case ({op.push, op.pop})
                2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
                2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_addr      = origin + s_q.wp;
    assign rd_addr      = origin + s_q.rp;
    assign rd_next_addr = origin + rp_inc;
    assign level        = s_q.cnt;
    assign full         = (s_q.cnt >= cap);
    assign afull        = (({1'b0, s_q.cnt} + {1'b0, s_q.af}) >= {1'b0, cap});
    assign aempty       = (s_q.cnt <= s_q.ae);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op.push |-> !full);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op.pop |-> (s_q.cnt != '0));

    // R2
    level_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= cap);

    // R11
    cfg_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op.cfg |=> (level == '0));

endmodule

// File: rtl/mq_ram.sv
module mq_ram #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Write-through so a word written this cycle can be captured at once
    always_comb begin
        if (we && (waddr == raddr)) rdata = wdata;
        else                        rdata = mem[raddr];
    end

endmodule

// File: rtl/mq_read_port.sv
module mq_read_port #(
    parameter int NQ     = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 11,
    localparam int QSEL_W = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic                        rd_en,
    input  logic [QSEL_W-1:0]           rd_sel,
    input  logic [NQ-1:0][CNT_W-1:0]    level,
    input  logic [NQ-1:0][ADDR_W-1:0]   head_addr,
    input  logic [NQ-1:0][ADDR_W-1:0]   next_addr,
    input  logic [NQ-1:0]               push,
    input  logic [DATA_W-1:0]           ram_rdata,
    output logic [ADDR_W-1:0]           ram_raddr,
    output logic [NQ-1:0]               pop_vec,
    output logic [QSEL_W-1:0]           cur_sel,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data
);

    typedef struct packed {
        logic [QSEL_W-1:0] sel;
        logic              ov;
        logic [DATA_W-1:0] dout;
    } rstate_t;

    rstate_t          s_q, s_d;
    logic             take;
    logic [CNT_W-1:0] avail;

    always_comb begin
        s_d       = s_q;
        s_d.sel   = rd_sel;
        pop_vec   = '0;
        ram_raddr = head_addr[s_q.sel];
        take      = 1'b0;
        avail     = '0;
        if (!cfg_we && (rd_sel == s_q.sel)) begin
            take  = s_q.ov && rd_en;
            avail = level[s_q.sel] - CNT_W'(take) + CNT_W'(push[s_q.sel]);
            if (take || !s_q.ov) begin
                if (take) ram_raddr = next_addr[s_q.sel];
                if (avail != '0) begin
                    s_d.ov   = 1'b1;
                    s_d.dout = ram_rdata;
                end else begin
                    s_d.ov   = 1'b0;
                end
            end
            pop_vec[s_q.sel] = take;
        end else begin
            // Queue switch or configuration: refill on a later cycle
            s_d.ov = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_sel  = s_q.sel;
    assign rd_valid = s_q.ov;
    assign rd_data  = s_q.dout;

    // R7
    switch_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel != s_q.sel) |=> !rd_valid);

    // R7
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));

    // R6
    valid_has_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (level[s_q.sel] != '0));

    // R6
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_vec));

endmodule

// File: rtl/mq_fifo.sv
module mq_fifo
    import mq_pkg::*;
#(
    parameter int NQ        = 4,
    parameter int DATA_W    = 32,
    parameter int BLK_WORDS = 256,
    parameter int NBLK      = 4,
    localparam int QSEL_W   = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int ADDR_W   = $clog2(NBLK * BLK_WORDS),
    localparam int CNT_W    = ADDR_W + 1,
    localparam int BIDX_W   = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int BCNT_W   = $clog2(NBLK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [QSEL_W-1:0] cfg_q,
    input  logic [BIDX_W-1:0] cfg_base,
    input  logic [BCNT_W-1:0] cfg_blocks,
    input  logic [CNT_W-1:0]  cfg_af_off,
    input  logic [CNT_W-1:0]  cfg_ae_off,
    input  logic              wr_en,
    input  logic [QSEL_W-1:0] wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              almost_full,
    input  logic              rd_en,
    input  logic [QSEL_W-1:0] rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              almost_empty
);

    q_op_t                     ops      [NQ];
    logic [NQ-1:0][ADDR_W-1:0] q_waddr;
    logic [NQ-1:0][ADDR_W-1:0] q_raddr;
    logic [NQ-1:0][ADDR_W-1:0] q_rnext;
    logic [NQ-1:0][CNT_W-1:0]  q_level;
    logic [NQ-1:0]             q_full;
    logic [NQ-1:0]             q_afull;
    logic [NQ-1:0]             q_aempty;
    logic [NQ-1:0]             push_vec;
    logic [NQ-1:0]             pop_vec;
    logic [QSEL_W-1:0]         cur_sel;
    logic [ADDR_W-1:0]         ram_raddr;
    logic [DATA_W-1:0]         ram_rdata;
    logic                      wr_ok;

    always_comb begin
        wr_ok = wr_en && !q_full[wr_sel] && !cfg_we;
        for (int i = 0; i < NQ; i++) begin
            push_vec[i]  = wr_ok && (wr_sel == QSEL_W'(i));
            ops[i].cfg   = cfg_we && (cfg_q == QSEL_W'(i));
            ops[i].push  = push_vec[i];
            ops[i].pop   = pop_vec[i];
        end
    end

    for (genvar g = 0; g < NQ; g++) begin : g_queue
        mq_queue_ctl #(
            .BLK_WORDS (BLK_WORDS),
            .NBLK      (NBLK)
        ) u_ctl (
            .clk          (clk),
            .rst_n        (rst_n),
            .op           (ops[g]),
            .cfg_base     (cfg_base),
            .cfg_blocks   (cfg_blocks),
            .cfg_af       (cfg_af_off),
            .cfg_ae       (cfg_ae_off),
            .wr_addr      (q_waddr[g]),
            .rd_addr      (q_raddr[g]),
            .rd_next_addr (q_rnext[g]),
            .level        (q_level[g]),
            .full         (q_full[g]),
            .afull        (q_afull[g]),
            .aempty       (q_aempty[g])
        );
    end

    mq_ram #(
        .DATA_W (DATA_W),
        .DEPTH  (NBLK * BLK_WORDS)
    ) u_ram (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (q_waddr[wr_sel]),
        .wdata (wr_data),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    mq_read_port #(
        .NQ     (NQ),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel),
        .level     (q_level),
        .head_addr (q_raddr),
        .next_addr (q_rnext),
        .push      (push_vec),
        .ram_rdata (ram_rdata),
        .ram_raddr (ram_raddr),
        .pop_vec   (pop_vec),
        .cur_sel   (cur_sel),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    assign full         = q_full[wr_sel];
    assign almost_full  = q_afull[wr_sel];
    assign almost_empty = q_aempty[cur_sel];

    // R4
    write_one_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push_vec));

    // R11
    cfg_blocks_traffic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> (push_vec == '0 && pop_vec == '0));

endmodule

// File: tb/mq_fifo_bench.sv
module mq_fifo_bench;

    localparam int NQ  = 4;
    localparam int DW  = 32;
    localparam int BW  = 256;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [1:0]    cfg_q;
    logic [1:0]    cfg_base;
    logic [2:0]    cfg_blocks;
    logic [10:0]   cfg_af_off;
    logic [10:0]   cfg_ae_off;
    logic          wr_en;
    logic [1:0]    wr_sel;
    logic [DW-1:0] wr_data;
    logic          full;
    logic          almost_full;
    logic          rd_en;
    logic [1:0]    rd_sel;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          almost_empty;

    always #4 clk = ~clk;

    mq_fifo u_mq_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_q        (cfg_q),
        .cfg_base     (cfg_base),
        .cfg_blocks   (cfg_blocks),
        .cfg_af_off   (cfg_af_off),
        .cfg_ae_off   (cfg_ae_off),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .full         (full),
        .almost_full  (almost_full),
        .rd_en        (rd_en),
        .rd_sel       (rd_sel),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .almost_empty (almost_empty)
    );

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";

    typedef logic [DW-1:0] wq_t[$];
    wq_t           mq [NQ];
    int            cap [NQ];
    int            afo [NQ];
    int            aeo [NQ];
    int            msel = 0;
    bit            mov  = 1'b0;
    logic [DW-1:0] mdout = '0;

    task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s): actual %0h expected %0h at %0t", what, phase, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R4 full", DW'(full), DW'(mq[wr_sel].size() >= cap[wr_sel]));
        chk("R8 almost_full", DW'(almost_full), DW'(mq[wr_sel].size() + afo[wr_sel] >= cap[wr_sel]));
        chk("R9 almost_empty", DW'(almost_empty), DW'(mq[msel].size() <= aeo[msel]));
        chk("R6 rd_valid", DW'(rd_valid), DW'(mov));
        chk("R5 rd_data", rd_data, mdout);
    endtask

    task automatic model_step();
        bit wacc;
        bit take;
        if (cfg_we) begin
            mq[cfg_q].delete();
            cap[cfg_q] = int'(cfg_blocks) * BW;
            afo[cfg_q] = int'(cfg_af_off);
            aeo[cfg_q] = int'(cfg_ae_off);
            mov  = 1'b0;
            msel = int'(rd_sel);
            return;
        end
        wacc = wr_en && (mq[wr_sel].size() < cap[wr_sel]);
        if (int'(rd_sel) != msel) begin
            if (wacc) mq[wr_sel].push_back(wr_data);
            mov = 1'b0;
        end else begin
            take = mov && rd_en;
            if (take) void'(mq[msel].pop_front());
            if (wacc) mq[wr_sel].push_back(wr_data);
            if (take || !mov) begin
                if (mq[msel].size() > 0) begin
                    mdout = mq[msel][0];
                    mov   = 1'b1;
                end else begin
                    mov   = 1'b0;
                end
            end
        end
        msel = int'(rd_sel);
    endtask

    // Inputs were set just after a falling edge; check, advance the model, wait
    task automatic tick();
        #1;
        compare();
        model_step();
        @(negedge clk);
    endtask

    task automatic configure(int q, int base, int blocks, int af, int ae);
        cfg_we     = 1'b1;
        cfg_q      = 2'(q);
        cfg_base   = 2'(base);
        cfg_blocks = 3'(blocks);
        cfg_af_off = 11'(af);
        cfg_ae_off = 11'(ae);
        tick();
        cfg_we     = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NQ; i++) begin
            cap[i] = 0;
            afo[i] = 0;
            aeo[i] = 0;
        end
        rst_n = 1'b0;
        cfg_we = 1'b0; cfg_q = '0; cfg_base = '0; cfg_blocks = '0;
        cfg_af_off = '0; cfg_ae_off = '0;
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        rd_en = 1'b0; rd_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: state straight after reset
        phase = "R1";
        tick(); tick();

        // R2: allocate blocks
        phase = "R2";
        configure(0, 0, 1, 4, 2);
        configure(1, 1, 2, 8, 3);
        configure(2, 3, 1, 0, 0);
        configure(3, 0, 0, 0, 0);

        // R3: zero-block queue discards writes and never presents data
        phase = "R3";
        rd_sel = 2'd3;
        for (int i = 0; i < 4; i++) begin
            wr_en = 1'b1; wr_sel = 2'd3; wr_data = 32'hdead0000 + i;
            tick();
        end
        wr_en = 1'b0;
        tick(); tick();

        // R4 and R8: fill queue 0 past its capacity while reading an empty queue
        phase = "R4";
        rd_sel = 2'd1;
        for (int i = 0; i < 262; i++) begin
            wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h1000_0000 + i;
            tick();
        end
        wr_en = 1'b0;

        // R7: switch to the full queue, then drain some words
        phase = "R7";
        rd_sel = 2'd0;
        tick(); tick(); tick();
        phase = "R6";
        rd_en = 1'b1;
        for (int i = 0; i < 6; i++) tick();
        rd_en = 1'b0;
        tick();

        // R7: switch to an empty queue keeps the old word
        phase = "R7";
        rd_sel = 2'd2;
        rd_en  = 1'b1;
        for (int i = 0; i < 4; i++) tick();

        // R10: writes into the selected empty queue with reads in flight
        phase = "R10";
        for (int i = 0; i < 30; i++) begin
            wr_en = (i % 3) != 2; wr_sel = 2'd2; wr_data = 32'h2000_0000 + i;
            rd_en = (i % 4) != 0;
            tick();
        end
        wr_en = 1'b0;
        rd_en = 1'b0;
        tick();

        // R11: configuration cycle with traffic requested
        phase = "R11";
        rd_sel = 2'd0;
        tick(); tick();
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'h3000_0001; rd_en = 1'b1;
        cfg_we = 1'b1; cfg_q = 2'd2; cfg_base = 2'd3; cfg_blocks = 3'd1;
        cfg_af_off = 11'd16; cfg_ae_off = 11'd5;
        tick();
        cfg_we = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        tick(); tick();

        // R5: random traffic with rare read-queue changes
        phase = "R5";
        for (int i = 0; i < 6000; i++) begin
            wr_en   = ($urandom % 2) == 0;
            wr_sel  = 2'($urandom % NQ);
            wr_data = $urandom;
            rd_en   = ($urandom % 3) != 0;
            if (($urandom % 16) == 0) rd_sel = 2'($urandom % NQ);
            tick();
        end

        // R6: drain every queue to the end
        phase = "R6";
        wr_en = 1'b0;
        rd_en = 1'b1;
        for (int q = 0; q < NQ; q++) begin
            rd_sel = 2'(q);
            for (int i = 0; i < 600; i++) tick();
        end

        summary();
        $finish;
    end

endmodule